// File: doc/BRIEF.md
# Little-Endian Bus Bridge with Address Demunging

This block sits between the big-endian internal bus of a 32-bit core and a little-endian external system bus. The core runs little-endian code and data without change: it issues addresses whose low two bits have been scrambled according to the access width, and it places data on its big-endian byte lanes. The bridge undoes the address scrambling, reverses the byte lanes, derives external byte enables, and hands read data back in internal lane order.

Both sides use a request/acknowledge handshake. The bridge holds one transaction at a time. It captures a request when the core raises a request while the bridge reports ready. It then drives the external cycle until the external side acknowledges, and finally returns a one-cycle acknowledge to the core. A request that is not naturally aligned is refused with an error flag and never reaches the external bus.

Top module: `endian_bridge`

## Requirements
- R1: While reset is high and in the first cycle after it, `in_ready` is 1 and `in_ack`, `in_err` and `ext_req` are 0.
- R2: A request is captured at a rising edge where `in_req` and `in_ready` are both 1. `in_ready` stays 0 from that edge until the acknowledge cycle has ended.
- R3: `in_size` = 2 selects a word access. `ext_addr` equals `in_addr` (low two bits XOR 0).
- R4: `in_size` = 1 selects a half-word access. `ext_addr` equals `in_addr` with its low two bits XOR 2, and the upper bits are unchanged.
- R5: `in_size` = 0 selects a byte access. `ext_addr` equals `in_addr` with its low two bits XOR 3, and the upper bits are unchanged.
- R6: Bit n of `ext_be` enables external bits [8n+7:8n]. For a demunged offset o, a byte gives 1<<o, a half-word gives 3<<o, and a word gives 4'hF.
- R7: Write data is byte-reversed. Internal bits [8k+7:8k] appear on external bits [8(3-k)+7:8(3-k)], so 32'h11121314 is driven as 32'h14131211. `ext_we` follows `in_we`.
- R8: Once `ext_req` rises, it stays high with `ext_addr`, `ext_be`, `ext_we` and `ext_wdata` unchanged until a cycle in which `ext_ack` is high.
- R9: `in_ack` is high for exactly the one cycle after the edge that samples `ext_ack`. On a read, `in_rdata` then holds the byte-reversed external data, with lanes not enabled by `ext_be` forced to 0.
- R10: A half-word at an odd address, a word at an address with nonzero low bits, or `in_size` = 3 is refused. `in_ack` and `in_err` are both high in the cycle after capture, and `ext_req` never rises for it.
- R11: `in_rdata` is 0 during the acknowledge of a write or a refused request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | 1 | Internal request |
| in_ready | output | 1 | Bridge can capture a request |
| in_we | input | 1 | 1 = write, 0 = read |
| in_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| in_addr | input | ADDR_W | Munged internal address |
| in_wdata | input | 32 | Write data, big-endian lane order |
| in_ack | output | 1 | One-cycle completion strobe |
| in_err | output | 1 | Request refused (valid with in_ack) |
| in_rdata | output | 32 | Read data, big-endian lane order |
| ext_req | output | 1 | External cycle in progress |
| ext_we | output | 1 | External write strobe |
| ext_addr | output | ADDR_W | Demunged little-endian address |
| ext_be | output | 4 | External byte enables |
| ext_wdata | output | 32 | Write data, little-endian lane order |
| ext_rdata | input | 32 | External read data |
| ext_ack | input | 1 | External cycle completion |

## Verification
Accesses are issued at every munged offset for bytes and at both offsets for half-words, as reads and as writes. Words are issued at two base addresses. Every external read returns a full word of distinct bytes, so a wrong XOR key, a wrong enable shift or a missing lane mask shows up as a different byte in a known lane. External latency is varied between zero and several cycles to separate acknowledge timing from hold behaviour. Misaligned half-words, misaligned words and the reserved size check that refusal starts no external cycle.

// File: rtl/endian_bridge_pkg.sv
package endian_bridge_pkg;

    localparam int LANES  = 4;
    localparam int DATA_W = LANES * 8;
    localparam int OFFS_W = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_BUS  = 2'd1,
        PH_RESP = 2'd2
    } phase_e;

    typedef struct packed {
        logic [OFFS_W-1:0] offs;
        logic [LANES-1:0]  be;
        logic              bad;
    } lane_sel_t;

    // Size-dependent key: applying it twice restores the original offset.
    function automatic logic [OFFS_W-1:0] munge_key(acc_size_e sz);
        case (sz)
            SZ_BYTE: return OFFS_W'(LANES - 1);
            SZ_HALF: return OFFS_W'(LANES - 2);
            default: return '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] be_to_mask(logic [LANES-1:0] be);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[8*i +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/eb_addr_xlate.sv
module eb_addr_xlate
    import endian_bridge_pkg::*;
(
    input  acc_size_e         size,
    input  logic [OFFS_W-1:0] offs_in,
    output lane_sel_t         sel
);

    logic [OFFS_W-1:0] true_offs;
    logic [LANES-1:0]  be_raw;
    logic              misaligned;

    always_comb begin
        true_offs  = offs_in ^ munge_key(size);
        be_raw     = '0;
        misaligned = 1'b0;
        case (size)
            SZ_BYTE: be_raw = LANES'(1) << true_offs;
            SZ_HALF: begin
                be_raw     = LANES'(3) << true_offs;
                misaligned = true_offs[0];
            end
            SZ_WORD: begin
                be_raw     = '1;
                misaligned = |true_offs;
            end
            default: misaligned = 1'b1;
        endcase
        sel.offs = true_offs;
        sel.bad  = misaligned;
        sel.be   = misaligned ? '0 : be_raw;
    end

endmodule

// File: rtl/eb_lane_mirror.sv
module eb_lane_mirror #(
    parameter int LANES_P = 4
) (
    input  logic [LANES_P*8-1:0] d,
    output logic [LANES_P*8-1:0] q
);

    for (genvar g = 0; g < LANES_P; g++) begin : g_lane
        assign q[8*g +: 8] = d[8*(LANES_P-1-g) +: 8];
    end

endmodule

// File: rtl/endian_bridge.sv
module endian_bridge
    import endian_bridge_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_req,
    output logic              in_ready,
    input  logic              in_we,
    input  logic [1:0]        in_size,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    output logic              in_ack,
    output logic              in_err,
    output logic [DATA_W-1:0] in_rdata,
    output logic              ext_req,
    output logic              ext_we,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [LANES-1:0]  ext_be,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic [DATA_W-1:0] ext_rdata,
    input  logic              ext_ack
);

    phase_e            phase;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  be_q;
    logic              we_q;
    logic              err_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    lane_sel_t         sel;
    logic [DATA_W-1:0] wdata_mir;
    logic [DATA_W-1:0] rdata_mir;
    logic [DATA_W-1:0] rdata_masked;

    eb_addr_xlate u_xlate (
        .size    (acc_size_e'(in_size)),
        .offs_in (in_addr[OFFS_W-1:0]),
        .sel     (sel)
    );

    eb_lane_mirror #(.LANES_P(LANES)) u_wmir (
        .d (in_wdata),
        .q (wdata_mir)
    );

    assign rdata_masked = ext_rdata & be_to_mask(be_q);

    eb_lane_mirror #(.LANES_P(LANES)) u_rmir (
        .d (rdata_masked),
        .q (rdata_mir)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            addr_q  <= '0;
            be_q    <= '0;
            we_q    <= 1'b0;
            err_q   <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (in_req) begin
                        addr_q  <= {in_addr[ADDR_W-1:OFFS_W], sel.offs};
                        be_q    <= sel.be;
                        we_q    <= in_we;
                        err_q   <= sel.bad;
                        wdata_q <= wdata_mir;
                        rdata_q <= '0;
                        phase   <= sel.bad ? PH_RESP : PH_BUS;
                    end
                end
                PH_BUS: begin
                    if (ext_ack) begin
                        if (!we_q) begin
                            rdata_q <= rdata_mir;
                        end
                        phase <= PH_RESP;
                    end
                end
                PH_RESP: begin
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign in_ready  = (phase == PH_IDLE);
    assign in_ack    = (phase == PH_RESP);
    assign in_err    = in_ack & err_q;
    assign in_rdata  = rdata_q;
    assign ext_req   = (phase == PH_BUS);
    assign ext_we    = we_q;
    assign ext_addr  = addr_q;
    assign ext_be    = be_q;
    assign ext_wdata = wdata_q;

endmodule

// File: rtl/endian_bridge_checker.sv
module endian_bridge_checker
    import endian_bridge_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_req,
    input logic              in_ready,
    input logic              in_we,
    input logic [1:0]        in_size,
    input logic [ADDR_W-1:0] in_addr,
    input logic [DATA_W-1:0] in_wdata,
    input logic              in_ack,
    input logic              in_err,
    input logic [DATA_W-1:0] in_rdata,
    input logic              ext_req,
    input logic              ext_we,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [LANES-1:0]  ext_be,
    input logic [DATA_W-1:0] ext_wdata,
    input logic [DATA_W-1:0] ext_rdata,
    input logic              ext_ack
);

    function automatic logic [1:0] chk_key(logic [1:0] sz);
        return (sz == 2'd0) ? 2'b11 : (sz == 2'd1) ? 2'b10 : 2'b00;
    endfunction

    function automatic logic chk_bad(logic [1:0] sz, logic [1:0] lo);
        return (sz == 2'd3) || (sz == 2'd1 && lo[0]) || (sz == 2'd2 && lo != 2'b00);
    endfunction

    logic take;
    assign take = in_req && in_ready;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (in_ready && !in_ack && !ext_req)); // R1

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (ext_req || in_ack) |-> !in_ready); // R2

    AST_ADDR_DEMUNGE: assert property (@(posedge clk) disable iff (rst)
        (take && !chk_bad(in_size, in_addr[1:0])) |=>
        (ext_req && ext_addr[1:0] == ($past(in_addr[1:0]) ^ chk_key($past(in_size)))
                 && ext_addr[ADDR_W-1:2] == $past(in_addr[ADDR_W-1:2]))); // R3

    AST_BE_SHAPE: assert property (@(posedge clk) disable iff (rst)
        ext_req |-> ($countones(ext_be) == 1 || $countones(ext_be) == 2 ||
                     $countones(ext_be) == 4)); // R6

    AST_EXT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ext_req && !ext_ack) |=>
        (ext_req && $stable(ext_addr) && $stable(ext_be) && $stable(ext_we) &&
         $stable(ext_wdata))); // R8

    AST_ACK_AFTER_EXT: assert property (@(posedge clk) disable iff (rst)
        (ext_req && ext_ack) |=> (in_ack && !in_err)); // R9

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        in_ack |=> !in_ack); // R9

    AST_REFUSE_NO_EXT: assert property (@(posedge clk) disable iff (rst)
        (take && chk_bad(in_size, in_addr[1:0])) |=> (in_ack && in_err && !ext_req)); // R10

    AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        in_err |-> in_ack); // R10

endmodule

bind endian_bridge endian_bridge_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/endian_bridge_bench.sv
module endian_bridge_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_req, in_ready, in_we;
    logic [1:0]    in_size;
    logic [AW-1:0] in_addr;
    logic [31:0]   in_wdata;
    logic          in_ack, in_err;
    logic [31:0]   in_rdata;
    logic          ext_req, ext_we;
    logic [AW-1:0] ext_addr;
    logic [3:0]    ext_be;
    logic [31:0]   ext_wdata, ext_rdata;
    logic          ext_ack;

    always #(CLK_PERIOD/2) clk = ~clk;

    endian_bridge #(.ADDR_W(AW)) u_endian_bridge (
        .clk(clk), .rst(rst),
        .in_req(in_req), .in_ready(in_ready), .in_we(in_we), .in_size(in_size),
        .in_addr(in_addr), .in_wdata(in_wdata), .in_ack(in_ack), .in_err(in_err),
        .in_rdata(in_rdata), .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr),
        .ext_be(ext_be), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_ack(ext_ack)
    );

    typedef struct {
        logic [AW-1:0] addr;
        logic [3:0]    be;
        logic          we;
        logic [31:0]   wdata;
        logic [31:0]   rd;
        int            lat;
        string         atag;
    } ext_item_t;

    typedef struct {
        logic        err;
        logic [31:0] rdata;
        string       dtag;
    } resp_item_t;

    ext_item_t  ext_q[$];
    resp_item_t resp_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] swap32(logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    function automatic logic [31:0] lane_mask(logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    // Driver: computes expectations from the requirements, queues them, drives the request.
    task automatic access(logic [AW-1:0] a, logic [1:0] sz, logic we,
                          logic [31:0] wd, logic [31:0] rd, int lat);
        logic [1:0] key, o;
        logic       bad;
        logic [3:0] be;
        ext_item_t  ei;
        resp_item_t ri;
        key = (sz == 2'd0) ? 2'd3 : (sz == 2'd1) ? 2'd2 : 2'd0;
        o   = a[1:0] ^ key;
        bad = (sz == 2'd3) || (sz == 2'd1 && o[0]) || (sz == 2'd2 && o != 2'd0);
        be  = (sz == 2'd0) ? (4'b0001 << o) : (sz == 2'd1) ? (4'b0011 << o) : 4'b1111;
        if (!bad) begin
            ei.addr  = {a[AW-1:2], o};
            ei.be    = be;
            ei.we    = we;
            ei.wdata = swap32(wd);
            ei.rd    = rd;
            ei.lat   = lat;
            ei.atag  = (sz == 2'd0) ? "R5" : (sz == 2'd1) ? "R4" : "R3";
            ext_q.push_back(ei);
        end
        ri.err   = bad;
        ri.rdata = (bad || we) ? 32'h0 : swap32(rd & lane_mask(be));
        ri.dtag  = (bad || we) ? "R11" : "R9";
        resp_q.push_back(ri);

        @(negedge clk);
        in_req = 1'b1; in_addr = a; in_size = sz; in_we = we; in_wdata = wd;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_req = 1'b0;
        while (!in_ack) @(negedge clk);
        @(negedge clk);
    endtask

    // External responder: compares each external cycle against the queue.
    initial begin
        ext_ack = 1'b0;
        ext_rdata = '0;
        forever begin
            @(negedge clk);
            if (!rst && ext_req) begin
                if (ext_q.size() == 0) begin
                    check(1'b0, "R10 unexpected ext_req", ext_addr, 32'h0);
                end else begin
                    ext_item_t e;
                    e = ext_q.pop_front();
                    check(ext_addr == e.addr, e.atag, ext_addr, e.addr);
                    check(ext_be == e.be, "R6", 32'(ext_be), 32'(e.be));
                    check(ext_we == e.we, "R7 we", 32'(ext_we), 32'(e.we));
                    if (e.we) check(ext_wdata == e.wdata, "R7", ext_wdata, e.wdata);
                    check(in_ready == 1'b0, "R2", 32'(in_ready), 32'h0);
                    repeat (e.lat) @(negedge clk);
                    check(ext_req && ext_addr == e.addr && ext_be == e.be, "R8",
                          ext_addr, e.addr);
                    ext_rdata = e.rd;
                    ext_ack = 1'b1;
                    @(negedge clk);
                    ext_ack = 1'b0;
                    ext_rdata = '0;
                    check(in_ack == 1'b1, "R9 ack timing", 32'(in_ack), 32'h1);
                end
            end
        end
    end

    // Monitor: compares each acknowledge with the oldest expected response.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && in_ack) begin
                if (resp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected in_ack", 32'(in_ack), 32'h0);
                end else begin
                    resp_item_t r;
                    r = resp_q.pop_front();
                    check(in_err == r.err, "R10", 32'(in_err), 32'(r.err));
                    check(in_rdata == r.rdata, r.dtag, in_rdata, r.rdata);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            check(1'b0, "R9 watchdog expired", 32'h0, 32'h1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_req = 1'b0; in_we = 1'b0; in_size = 2'd0;
        in_addr = '0; in_wdata = '0;
        repeat (3) @(negedge clk);
        check(in_ready && !in_ack && !in_err && !ext_req, "R1 in reset",
              {in_ready, in_ack, in_err, ext_req}, 32'h8);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready && !in_ack && !in_err && !ext_req, "R1 after reset",
              {in_ready, in_ack, in_err, ext_req}, 32'h8);

        // Words (R3, R7, R9)
        access(32'h0000_0100, 2'd2, 1'b1, 32'h1112_1314, 32'h0, 0);
        access(32'h0000_0104, 2'd2, 1'b0, 32'h0, 32'hAABB_CCDD, 2);
        // Half-words at both offsets (R4, R6)
        access(32'h0000_0202, 2'd1, 1'b1, 32'h2122_5A5A, 32'h0, 1);
        access(32'h0000_0200, 2'd1, 1'b1, 32'h3132_A5A5, 32'h0, 0);
        access(32'h0000_0202, 2'd1, 1'b0, 32'h0, 32'h4433_2211, 3);
        access(32'h0000_0200, 2'd1, 1'b0, 32'h0, 32'h4433_2211, 0);
        // Bytes at every munged offset (R5, R6)
        for (int k = 0; k < 4; k++) begin
            access(32'h0000_0300 | 32'(k), 2'd0, 1'b0, 32'h0, 32'h8877_6655, k);
            access(32'h0000_0310 | 32'(k), 2'd0, 1'b1, 32'hC1C2_C3C4, 32'h0, 1);
        end
        // Refused requests (R10, R11)
        access(32'h0000_0401, 2'd1, 1'b0, 32'h0, 32'hFFFF_FFFF, 0);
        access(32'h0000_0402, 2'd2, 1'b1, 32'hDEAD_BEEF, 32'h0, 0);
        access(32'h0000_0400, 2'd3, 1'b0, 32'h0, 32'h0, 0);
        // Back to a normal read after refusals
        access(32'h0000_0408, 2'd2, 1'b0, 32'h0, 32'h0102_0304, 4);

        repeat (3) @(negedge clk);
        check(resp_q.size() == 0 && ext_q.size() == 0, "R9 all drained",
              32'(resp_q.size() + ext_q.size()), 32'h0);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule